// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds the program-visible working registers of a small processor datapath: eight 32-bit words by default. Two read ports run in parallel. Each takes a 4-bit register number and drives back that register's contents with no clock involved, so decode logic can fetch two operands in the same cycle it presents their numbers. A single write port takes a register number and a data word, and the word is stored on the rising clock edge.

Any register number at or above the register count is a "no register" code. The lowest such code, 8 in the default build, is the one a datapath drives when an instruction has no source or no destination. A read port given a no-register code outputs zero. A write with a no-register code stores nothing. A synchronous reset clears every register. A write port never forwards to a read port: a read of the register being written shows the old contents until the edge and the new contents after it. A parameter chooses between an indexed multiplexer and an AND-OR selector for the read path.

Top module: `regbank_2r1w`

## Requirements
- R1: Read port A drives the stored word of register `rda_sel` whenever `rda_sel` is below 8, with no clock edge needed after the number changes.
- R2: Read port B behaves like port A and is fully independent of it: any pair of numbers can be read at the same time.
- R3: When `wr_sel` is below 8 and reset is low, the word on `wr_word` is stored into that register at the rising clock edge. A read of that register shows the old word before the edge and the new word after it.
- R4: When `wr_sel` is 8 or above, a clock edge leaves every register unchanged, whatever `wr_word` holds.
- R5: A read port given a number of 8 or above drives all zeros.
- R6: When `rst` is high at a rising edge, every register is zero after that edge, even if a write was requested in the same cycle.
- R7: A write changes only the addressed register. Every other register keeps its word.
- R8: When both read ports are given the same number, they drive the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rda_sel | input | 4 | Register number for read port A |
| rda_word | output | 32 | Word read on port A (zero for a no-register code) |
| rdb_sel | input | 4 | Register number for read port B |
| rdb_word | output | 32 | Word read on port B (zero for a no-register code) |
| wr_sel | input | 4 | Register number for the write port (8 or above: no write) |
| wr_word | input | 32 | Data word for the write port |

## Verification
Read results are due in the same cycle: the bench changes a read number at the falling edge and samples one time unit later, with no clock edge in between. Writes and reset are due exactly one rising edge after they are presented. The bench therefore samples a read of the target register just before that edge, expecting the old word, and again just after it, expecting the new word. No-register writes and the reset-with-write case are judged by sweeping every register through both read ports after the edge, against a model array that the bench updates from the requirements alone.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // Read-path variant selector
   typedef enum logic {
      READ_MUX   = 1'b0,
      READ_ANDOR = 1'b1
   } rd_style_e;

   // True when a register number names a real register
   function automatic logic id_is_real(input int unsigned id, input int unsigned num_regs);
      return id < num_regs;
   endfunction

endpackage

// File: rtl/rf_id_decode.sv
module rf_id_decode #(
   parameter int NUM_REGS = 8,
   parameter int ID_W     = 4
) (
   input  logic [ID_W-1:0]     id,
   output logic                hit,
   output logic [NUM_REGS-1:0] onehot
);

   always_comb begin
      onehot = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (id == ID_W'(i)) onehot[i] = 1'b1;
      end
      hit = |onehot;
   end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int NUM_REGS  = 8,
   parameter int DATA_W    = 32,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REGS-1:0]        wr_en,
   input  logic [DATA_W-1:0]          wr_word,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      logic [DATA_W-1:0] word_q;

      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)            word_q <= '0;
            else if (wr_en[g])  word_q <= wr_word;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en[g]) word_q <= wr_word;
         end
      end

      assign regs_flat[g*DATA_W +: DATA_W] = word_q;
   end

   if (!HAS_RESET) begin : g_rst_unused
      logic rst_unused;
      assign rst_unused = rst;
   end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int               NUM_REGS = 8,
   parameter int               DATA_W   = 32,
   parameter int               ID_W     = 4,
   parameter rf_pkg::rd_style_e RD_STYLE = rf_pkg::READ_MUX
) (
   input  logic [ID_W-1:0]            sel,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]          word
);

   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (RD_STYLE == rf_pkg::READ_MUX) begin : g_mux
      logic [DATA_W-1:0] arr [NUM_REGS];
      logic              hit;

      always_comb begin
         for (int i = 0; i < NUM_REGS; i++) arr[i] = regs_flat[i*DATA_W +: DATA_W];
      end

      assign hit  = rf_pkg::id_is_real(int'(sel), NUM_REGS);
      assign word = hit ? arr[sel[IDX_W-1:0]] : '0;
   end else begin : g_andor
      logic [NUM_REGS-1:0] onehot;
      logic                hit_unused;

      rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_dec (
         .id     (sel),
         .hit    (hit_unused),
         .onehot (onehot)
      );

      always_comb begin
         word = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            word = word | (regs_flat[i*DATA_W +: DATA_W] & {DATA_W{onehot[i]}});
         end
      end
   end

endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w #(
   parameter int                NUM_REGS  = 8,
   parameter int                DATA_W    = 32,
   parameter int                ID_W      = 4,
   parameter bit                HAS_RESET = 1'b1,
   parameter rf_pkg::rd_style_e RD_STYLE  = rf_pkg::READ_MUX
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   rda_sel,
   output logic [DATA_W-1:0] rda_word,
   input  logic [ID_W-1:0]   rdb_sel,
   output logic [DATA_W-1:0] rdb_word,
   input  logic [ID_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0] wr_word
);

   localparam int FLAT_W = NUM_REGS * DATA_W;

   // Elaboration checks: a no-register code must exist
   if (NUM_REGS < 2) begin : g_chk_count
      $error("regbank_2r1w: NUM_REGS must be at least 2");
   end
   if (NUM_REGS >= (1 << ID_W)) begin : g_chk_idw
      $error("regbank_2r1w: ID_W too narrow to hold a no-register code");
   end
   if (DATA_W < 1) begin : g_chk_dw
      $error("regbank_2r1w: DATA_W must be positive");
   end

   logic [NUM_REGS-1:0] wr_en;
   logic                wr_hit_unused;
   logic [FLAT_W-1:0]   regs_flat;

   rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_wr_dec (
      .id     (wr_sel),
      .hit    (wr_hit_unused),
      .onehot (wr_en)
   );

   rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .HAS_RESET(HAS_RESET)) u_store (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_word   (wr_word),
      .regs_flat (regs_flat)
   );

   rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W), .RD_STYLE(RD_STYLE)) u_rd_a (
      .sel       (rda_sel),
      .regs_flat (regs_flat),
      .word      (rda_word)
   );

   rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W), .RD_STYLE(RD_STYLE)) u_rd_b (
      .sel       (rdb_sel),
      .regs_flat (regs_flat),
      .word      (rdb_word)
   );

endmodule

// File: rtl/regbank_2r1w_chk.sv
module regbank_2r1w_chk #(
   parameter int NUM_REGS  = 8,
   parameter int DATA_W    = 32,
   parameter int ID_W      = 4,
   parameter bit HAS_RESET = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [ID_W-1:0]   rda_sel,
   input logic [DATA_W-1:0] rda_word,
   input logic [ID_W-1:0]   rdb_sel,
   input logic [DATA_W-1:0] rdb_word,
   input logic [ID_W-1:0]   wr_sel,
   input logic [DATA_W-1:0] wr_word
);

   localparam logic [ID_W-1:0] FIRST_NULL = ID_W'(NUM_REGS);

   // R3: a real write is visible on port A one edge later
   p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_sel < FIRST_NULL) |=> (rda_sel != $past(wr_sel) || rda_word == $past(wr_word)));

   // R4: a no-register write leaves the word seen on a steady port unchanged
   p_null_write_keeps_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_sel >= FIRST_NULL) |=> (rda_sel != $past(rda_sel) || rda_word == $past(rda_word)));

   // R5: no-register reads give zero
   p_null_read_a_r5: assert property (@(posedge clk) disable iff (rst)
      (rda_sel >= FIRST_NULL) |-> (rda_word == '0));
   p_null_read_b_r5: assert property (@(posedge clk) disable iff (rst)
      (rdb_sel >= FIRST_NULL) |-> (rdb_word == '0));

   // R8: both ports agree on a shared register number
   p_ports_agree_r8: assert property (@(posedge clk) disable iff (rst)
      (rda_sel == rdb_sel) |-> (rda_word == rdb_word));

   // R6: reset clears the file
   if (HAS_RESET) begin : g_rst_chk
      p_reset_clears_r6: assert property (@(posedge clk)
         rst |=> (rda_word == '0 && rdb_word == '0));
   end

endmodule

bind regbank_2r1w regbank_2r1w_chk #(
   .NUM_REGS  (NUM_REGS),
   .DATA_W    (DATA_W),
   .ID_W      (ID_W),
   .HAS_RESET (HAS_RESET)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rda_sel  (rda_sel),
   .rda_word (rda_word),
   .rdb_sel  (rdb_sel),
   .rdb_word (rdb_word),
   .wr_sel   (wr_sel),
   .wr_word  (wr_word)
);

// File: tb/regbank_2r1w_bench.sv
module regbank_2r1w_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NREG = 8;
   localparam int DW   = 32;
   localparam int IW   = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic [IW-1:0] rda_sel, rdb_sel, wr_sel;
   logic [DW-1:0] rda_word, rdb_word, wr_word;

   logic [DW-1:0] model [NREG];
   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbank_2r1w u_regbank_2r1w (
      .clk      (clk),
      .rst      (rst),
      .rda_sel  (rda_sel),
      .rda_word (rda_word),
      .rdb_sel  (rdb_sel),
      .rdb_word (rdb_word),
      .wr_sel   (wr_sel),
      .wr_word  (wr_word)
   );

   function automatic logic [DW-1:0] expect_of(input int id);
      return (id < NREG) ? model[id] : '0;
   endfunction

   function automatic logic [DW-1:0] pattern(input int id, input int round);
      return (32'h13579BDF * (id + 1)) ^ (32'h0F0F0000 + 32'(round * 977));
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive both read numbers at the falling edge, sample 1 unit later
   task automatic read_pair(input int a, input int b, input string req);
      @(negedge clk);
      rda_sel = IW'(a);
      rdb_sel = IW'(b);
      #1;
      check(req, rda_word, expect_of(a));
      check(req, rdb_word, expect_of(b));
   endtask

   task automatic sweep_all(input string req);
      for (int i = 0; i < NREG + 2; i++) read_pair(i, NREG + 1 - i, req);
   endtask

   task automatic do_write(input int id, input logic [DW-1:0] data);
      @(negedge clk);
      wr_sel  = IW'(id);
      wr_word = data;
      @(posedge clk);
      if (id < NREG) model[id] = data;
      @(negedge clk);
      wr_sel = IW'(NREG);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      rda_sel = '0; rdb_sel = '0;
      wr_sel = IW'(NREG); wr_word = '0;
      for (int i = 0; i < NREG; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R6: reset state, every number on both ports
      for (int i = 0; i < 16; i++) read_pair(i, 15 - i, "R6 reset state");

      // R3/R7: write each register in turn, sweep all after each write
      for (int r = 0; r < 2; r++) begin
         for (int k = 0; k < NREG; k++) begin
            do_write(k, pattern(k, r));
            sweep_all("R3/R7 write then sweep");
         end
      end

      // R1/R2/R5/R8: every pair of numbers on the two ports
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            read_pair(a, b, (a == b) ? "R8 same number" :
                            ((a >= NREG || b >= NREG) ? "R5 null read" : "R1/R2 pair read"));

      // R3: old value before edge, new after edge, same register
      for (int k = 0; k < NREG; k++) begin
         @(negedge clk);
         rda_sel = IW'(k);
         rdb_sel = IW'(k);
         wr_sel  = IW'(k);
         wr_word = ~model[k];
         #1;
         check("R3 old before edge", rda_word, model[k]);
         @(posedge clk);
         model[k] = ~model[k];
         #1;
         check("R3 new after edge", rda_word, model[k]);
         check("R3 new after edge port B", rdb_word, model[k]);
         @(negedge clk);
         wr_sel = IW'(NREG);
      end

      // R4: every no-register code with a loud data word
      for (int n = NREG; n < 16; n++) begin
         do_write(n, 32'hDEAD0000 | 32'(n));
         sweep_all("R4 null write ignored");
      end

      // R6: reset wins over a write in the same cycle
      @(negedge clk);
      rst = 1'b1;
      wr_sel = 4'd2;
      wr_word = 32'hFFFF_FFFF;
      @(posedge clk);
      for (int i = 0; i < NREG; i++) model[i] = '0;
      @(negedge clk);
      rst = 1'b0;
      wr_sel = IW'(NREG);
      sweep_all("R6 reset over write");

      // R7: single write after reset touches one register only
      do_write(5, 32'h0000_5555);
      sweep_all("R7 isolated write");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule